// File: doc/BRIEF.md
# Dual-Policy Interrupt Pending Array

This block holds one pending flag per interrupt source for a small microcontroller core and tells the CPU when service is waiting. Each source is fixed at build time to one of two clearing policies. Sources of the first policy are cleared by hardware as soon as the CPU acknowledges them by index; they are hidden from software. Sources of the second policy survive the acknowledge and are cleared only when the service routine writes a zero to their position through a small register port.

A request strobe on any source sets its flag on the next clock edge. The request output to the CPU pulses for one clock when the array goes from empty to non-empty, and pulses again after any acknowledge that leaves something still pending, so the CPU returns for remaining work. Masking, priority and vector generation live elsewhere.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A high bit on `src_req` sets the matching bit of `pend_vec` at the next rising clock edge.
- R2: A hardware-cleared bit that is pending goes to 0 at the edge where `ack_valid` is high and `ack_idx` equals its index; an acknowledge naming another index leaves it set.
- R3: An acknowledge has no effect on any software-cleared bit.
- R4: Hardware-cleared bits read as 0 on `reg_rdata`, and a register write (`reg_wr` high) never changes them.
- R5: `reg_rdata` bit i shows pending bit i for every software-cleared source; such a bit clears only at an edge where `reg_wr` is high and `reg_wdata` bit i is 0.
- R6: Writing 1 to a software-cleared bit position leaves that bit unchanged; a write never sets a bit.
- R7: When a request and a clear (acknowledge or write of 0) reach the same bit at the same edge, the bit is pending afterwards.
- R8: `cpu_irq` is high during the clock after an edge at which `pend_vec` went from all zero to non-zero, or at which `ack_valid` was high and `pend_vec` is non-zero afterwards; otherwise it is low.
- R9: While `rst_n` is low at a rising edge, all pending bits and `cpu_irq` are 0 after that edge.
- R10: Bit i of parameter `HW_CLR_MASK` set to 1 makes source i hardware-cleared; the default mask makes only source 0, the timer overflow, hardware-cleared; `NUM_SRC` defaults to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | NUM_SRC | Per-source request strobes |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged source |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | NUM_SRC | Write data; 0 in a software-cleared position clears it |
| reg_rdata | output | NUM_SRC | Software-visible pending bits, hardware-cleared positions read 0 |
| cpu_irq | output | 1 | Service request pulse to the CPU |
| pend_vec | output | NUM_SRC | Full pending vector |

## Verification
The hardest situation to reach is a request landing on a bit in the same cycle that an acknowledge or a zero write clears it, combined with the re-request pulse that must follow an acknowledge only when other bits remain set. A directed sweep drives every source through each combination of request, matching acknowledge and zero write from the pending state, and a long pseudo-random run with dense acknowledges and writes produces many overlapping set/clear events against a cycle model held in the bench.

// File: rtl/irq_pend_pkg.sv
// Package: shared helpers for the interrupt pending array.
// Assumes callers pass a source count of at least 1.
package irq_pend_pkg;
    // Width of an index able to name every source (minimum 1 bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pend_bit.sv
// pend_bit: one pending flag. Set by a request, dropped by a clear,
// request dominant. The clear is already policy-selected by the parent.
// HW_CLEAR only selects which assertion applies.
module pend_bit #(
    parameter bit HW_CLEAR = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic pend
);
    // Flag register: reset low, request wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= req | (pend & ~clr);
    end

    assert_req_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pend);

    assert_req_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && clr) |=> pend);

    generate
        if (HW_CLEAR) begin : g_hw_chk
            assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !req) |=> !pend);
        end else begin : g_sw_chk
            assert_sw_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (pend && !clr) |=> pend);
        end
    endgenerate
endmodule

// File: rtl/irq_pulse.sv
// irq_pulse: builds the CPU request pulse. Fires when the array becomes
// non-empty, or when an acknowledge leaves work pending.
// Assumes any_next is the OR of the pending vector's next value.
module irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic any_now,
    input  logic any_next,
    input  logic ack_valid,
    output logic irq
);
    // Pulse register: one clock per empty->busy transition or per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= any_next & (~any_now | ack_valid);
    end

    assert_irq_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_now && any_next) |=> irq);
endmodule

// File: rtl/irq_pend_ctrl.sv
// irq_pend_ctrl: pending array with two clearing policies per source.
// Hardware-cleared sources (HW_CLR_MASK bit = 1) drop on acknowledge and are
// hidden from the register port; the others drop only on a write of 0.
// Assumes ack_idx is only meaningful while ack_valid is high.
module irq_pend_ctrl #(
    parameter int unsigned          NUM_SRC     = 8,
    parameter logic [NUM_SRC-1:0]   HW_CLR_MASK = NUM_SRC'(1),
    localparam int unsigned         IDX_W       = irq_pend_pkg::idx_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    input  logic               reg_wr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               cpu_irq,
    output logic [NUM_SRC-1:0] pend_vec
);
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend_next;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            // Clear source picked by the build-time policy of this bit.
            if (HW_CLR_MASK[i]) begin : g_hw
                assign clr[i] = ack_valid && (ack_idx == IDX_W'(i));
            end else begin : g_sw
                assign clr[i] = reg_wr && !reg_wdata[i];
            end

            pend_bit #(.HW_CLEAR(HW_CLR_MASK[i])) u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (src_req[i]),
                .clr   (clr[i]),
                .pend  (pend_vec[i])
            );
        end
    endgenerate

    // Next-state view of the array, used only for the pulse decision.
    always_comb begin
        pend_next = src_req | (pend_vec & ~clr);
    end

    // Software view: hardware-cleared positions are not mapped.
    always_comb begin
        reg_rdata = pend_vec & ~HW_CLR_MASK;
    end

    irq_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_now   (|pend_vec),
        .any_next  (|pend_next),
        .ack_valid (ack_valid),
        .irq       (cpu_irq)
    );

    assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (|pend_vec));

    assert_hidden_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ((pend_vec & HW_CLR_MASK) != '0) && !ack_valid)
        |=> ((pend_vec & HW_CLR_MASK) != '0));
endmodule

// File: tb/sim_irq_pend_ctrl.sv
// Bench: directed per-source sweep plus pseudo-random run against a cycle model.
module sim_irq_pend_ctrl;
    localparam int unsigned N    = 8;
    localparam logic [N-1:0] HWM = 8'h35;
    localparam int unsigned IW   = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] src_req;
    logic         ack_valid;
    logic [IW-1:0] ack_idx;
    logic         reg_wr;
    logic [N-1:0] reg_wdata;
    logic [N-1:0] reg_rdata;
    logic         cpu_irq;
    logic [N-1:0] pend_vec;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_pend = '0;
    logic         exp_irq  = 1'b0;
    logic [31:0]  rs = 32'h1234_5678;

    always #4 clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(N), .HW_CLR_MASK(HWM)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .pend_vec(pend_vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of inputs, advance model, compare after the edge.
    task automatic step(input logic [N-1:0] rq, input logic av, input logic [IW-1:0] ai,
                        input logic wr, input logic [N-1:0] wd);
        logic [N-1:0] nxt;
        src_req = rq; ack_valid = av; ack_idx = ai; reg_wr = wr; reg_wdata = wd;
        for (int i = 0; i < N; i++) begin
            logic c;
            c = HWM[i] ? (av && ai == IW'(i)) : (wr && !wd[i]);
            nxt[i] = rq[i] | (exp_pend[i] & ~c);
        end
        exp_irq  = (|nxt) && ((exp_pend == '0) || av);
        exp_pend = nxt;
        @(posedge clk);
        @(negedge clk);
        check("R2 hw bits", 32'(pend_vec & HWM), 32'(exp_pend & HWM));
        check("R5 sw bits", 32'(pend_vec & ~HWM), 32'(exp_pend & ~HWM));
        check("R4 rdata", 32'(reg_rdata), 32'(exp_pend & ~HWM));
        check("R8 cpu_irq", 32'(cpu_irq), 32'(exp_irq));
    endtask

    task automatic idle();
        step('0, 1'b0, '0, 1'b0, '0);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req = '0; ack_valid = 0; ack_idx = '0; reg_wr = 0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 pend after reset", 32'(pend_vec), 0);
        check("R9 irq after reset", 32'(cpu_irq), 0);
        rst_n = 1'b1;

        // R1 / R8: single request sets bit and pulses once
        step(8'h01, 0, 0, 0, '0);
        check("R1 source 0 set", 32'(pend_vec[0]), 1);
        check("R8 pulse on rise", 32'(cpu_irq), 1);
        idle();
        check("R8 pulse one clock", 32'(cpu_irq), 0);
        // R10: source 0 (timer overflow) clears on its acknowledge
        step('0, 1, 3'd0, 0, '0);
        check("R10 source 0 hw cleared", 32'(pend_vec[0]), 0);

        // R6: write of ones cannot set, R4: write of zeros cannot clear hw bits
        step('0, 0, 0, 1, 8'hFF);
        check("R6 write ones no set", 32'(pend_vec), 0);
        step(8'hFF, 0, 0, 0, '0);
        step('0, 0, 0, 1, 8'hFF);
        check("R6 write ones keep", 32'(pend_vec), 32'hFF);
        step('0, 0, 0, 1, 8'h00);
        check("R4 hw bits survive write", 32'(pend_vec), 32'(HWM));
        // R3: acknowledge of sw source leaves it; R8 re-pulse after ack
        step(8'h02, 0, 0, 0, '0);
        step('0, 1, 3'd1, 0, '0);
        check("R3 ack ignores sw bit", 32'(pend_vec[1]), 1);
        check("R8 re-pulse after ack", 32'(cpu_irq), 1);
        step('0, 0, 0, 1, 8'h00);
        for (int i = 0; i < N; i++) step('0, 1, IW'(i), 0, '0);
        check("R2 all cleared", 32'(pend_vec), 0);

        // R7 and near-exhaustive per-source sweep of req/ack/write0 from pending
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 8; m++) begin
                logic [N-1:0] one;
                one = N'(1) << i;
                step(one, 0, 0, 0, '0);
                step(m[0] ? one : '0, m[1], IW'(i), m[2], ~one);
                if (m[0]) check("R7 request wins", 32'(pend_vec[i]), 1);
                step('0, 0, 0, 1, '0);
                for (int k = 0; k < N; k++) if (HWM[k]) step('0, 1, IW'(k), 0, '0);
            end
        end

        // Pseudo-random run
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] rq;
            rs = xs(rs);
            for (int i = 0; i < N; i++) rq[i] = (rs[3*i +: 3] == 3'd0);
            step(rq, rs[24] | rs[25], rs[28:26], rs[29] & rs[30], xs(rs ^ 32'h9E37_79B9) [N-1:0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule